// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Detection

This block compares, for each of two synthesizer channels, a reference pulse train against a feedback-divider pulse train. It runs on the reference-oscillator clock and expects both pulse trains as single-cycle pulses already in that clock domain. For every comparison it drives a pair of charge-pump switch controls (up, down). From these it derives a tri-state drive: an enable and a level, whose sense is set by a per-channel polarity bit. When both pulses arrive in the same cycle, both switches still close briefly, so the loop has no dead zone around zero error.

Each comparison also yields an error width: the number of oscillator cycles from the first arriving pulse to the second. A per-channel filter uses these widths for lock detection with hysteresis. A large error clears lock at once, and lock is granted only after a run of small errors. A channel held in power save drives nothing and counts as locked. The two channel states combine into one lock output. A monitor output shows either that lock output or one of the four raw pulse inputs.

Top module: `dual_pfd_lock`

## Requirements
- R1: After synchronous reset, with neither channel asleep, all pump controls and drive enables are 0 and `lock_o` is 0.
- R2: When a reference pulse leads its divider pulse by k cycles (k ≥ 1), `drv_en_o` is 1 for the k cycles after the reference pulse is captured. `drv_lvl_o` equals the polarity bit during those cycles (polarity 1 gives high).
- R3: When the divider pulse leads by k cycles, the drive is enabled for k cycles with `drv_lvl_o` equal to the inverse of the polarity bit.
- R4: Once both pulses of a comparison have arrived, including the same-cycle case, both `pump_up_o` and `pump_dn_o` are 1 for DZ_CYC (default 2) cycles with `drv_en_o` 0. After that both are 0.
- R5: A channel becomes locked after LOCK_RUN (default 3) consecutive comparisons with error width ≤ LOCK_MAX (default 6). Width 0 counts as small.
- R6: A comparison with width ≥ UNLOCK_MIN (default 10) clears the channel's lock. A width of 9 leaves it unchanged.
- R7: A width strictly between LOCK_MAX and UNLOCK_MIN leaves the lock flag unchanged and restarts the run of small errors.
- R8: While a channel's sleep input is 1, its pump controls and drive enable are 0, incoming pulses are ignored, and it counts as locked. On wake it restarts unlocked.
- R9: `lock_o` is 1 exactly when every channel is locked or asleep.
- R10: With `mon_lds_i` 0, `mon_o` equals `lock_o`. With `mon_lds_i` 1, `mon_src_i` selects the source: bit 0 picks the channel (0 or 1) and bit 1 picks divider (1) over reference (0), so 00 = reference ch0, 01 = reference ch1, 10 = divider ch0, 11 = divider ch1.
- R11: A repeat pulse on the already-arrived input of an open comparison is ignored; the width is measured from the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_i | input | 2 | Reference pulses, one bit per channel |
| fp_i | input | 2 | Divider pulses, one bit per channel |
| sleep_i | input | 2 | Power-save request per channel, active high |
| pol_i | input | 2 | Drive polarity per channel |
| mon_lds_i | input | 1 | Monitor mode: 0 lock, 1 raw pulse |
| mon_src_i | input | 2 | Monitor pulse source select |
| pump_up_o | output | 2 | Up switch control per channel |
| pump_dn_o | output | 2 | Down switch control per channel |
| drv_en_o | output | 2 | Tri-state drive enable per channel |
| drv_lvl_o | output | 2 | Drive level when enabled |
| lock_o | output | 1 | Combined lock |
| mon_o | output | 1 | Monitor output |

## Verification
Two events can fall in one cycle: the reference and divider pulses arriving together, and a channel entering sleep while a comparison is still open. Same-cycle arrival is provoked by pulsing both inputs on one edge. It is judged by both pump controls closing for exactly two cycles with the drive disabled, and by that comparison counting toward lock. Sleep is raised one cycle after a lone reference pulse. The bench expects the pump and drive outputs to drop in that same cycle, a following pulse to leave them quiet, and the channel to count as locked until it wakes unlocked.

// File: rtl/dpl_pkg.sv
// Package: shared selector encoding for the dual phase comparator.
// Assumes two channels; bit 0 of the selector picks the channel.
package dpl_pkg;
    typedef enum logic [1:0] {
        MON_REF_A = 2'b00,
        MON_REF_B = 2'b01,
        MON_DIV_A = 2'b10,
        MON_DIV_B = 2'b11
    } mon_src_e;
endpackage

// File: rtl/dpl_pfd.sv
// Module: edge-flag phase comparator for one channel.
// Latches which of the reference and divider pulses arrived first. It counts
// the cycles until the other one arrives, then holds both switches closed
// for DZ_CYC cycles. Assumes single-cycle pulses spaced further apart than
// one comparison plus the tail.
module dpl_pfd #(
    parameter int DZ_CYC = 2,
    parameter int ERR_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             fr_i,
    input  logic             fp_i,
    output logic             up_o,
    output logic             dn_o,
    output logic             meas_vld_o,
    output logic [ERR_W-1:0] meas_w_o
);
    localparam int TAIL_W = $clog2(DZ_CYC) + 1;
    localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(DZ_CYC - 1);

    logic              fr_seen, fp_seen;
    logic [TAIL_W-1:0] tail;
    logic [ERR_W-1:0]  gap;
    logic              both, fr_new, fp_new, closes;

    // Decode the arrival events of this cycle.
    always_comb begin
        both   = fr_seen & fp_seen;
        fr_new = fr_i & ~fr_seen;
        fp_new = fp_i & ~fp_seen;
        closes = ~both & ((fr_new & (fp_seen | fp_new)) | (fp_new & (fr_seen | fr_new)));
    end

    // Arrival flags, error gap counter, dead-zone tail and measurement.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_i) begin
            fr_seen    <= 1'b0;
            fp_seen    <= 1'b0;
            tail       <= '0;
            gap        <= '0;
            meas_vld_o <= 1'b0;
            meas_w_o   <= '0;
        end else begin
            meas_vld_o <= closes;
            if (closes)
                meas_w_o <= (fr_seen | fp_seen) ? ((gap == '1) ? gap : gap + 1'b1) : '0;
            if (both) begin
                if (tail == TAIL_LAST) begin
                    fr_seen <= 1'b0;
                    fp_seen <= 1'b0;
                    tail    <= '0;
                end else begin
                    tail <= tail + 1'b1;
                end
            end else begin
                if (fr_new) fr_seen <= 1'b1;
                if (fp_new) fp_seen <= 1'b1;
                if (closes)
                    gap <= '0;
                else if ((fr_seen ^ fp_seen) && gap != '1)
                    gap <= gap + 1'b1;
            end
        end
    end

    // Switch controls; sleep opens them without waiting for the clear.
    always_comb begin
        up_o = fr_seen & ~sleep_i;
        dn_o = fp_seen & ~sleep_i;
    end

    // R4: once both have arrived, the pair stays closed into the next cycle.
    if (DZ_CYC >= 2) begin : g_dz_chk
        a_r4_tail_holds: assert property (@(posedge clk) disable iff (!rst_n || sleep_i)
            $rose(fr_seen & fp_seen) |=> (fr_seen & fp_seen));
    end

    // R2: a measurement only follows a cycle with a pulse on an input.
    a_r2_meas_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld_o |-> $past(fr_i || fp_i));

    // R8: a sleeping channel holds no arrival state on the next cycle.
    a_r8_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !(fr_seen || fp_seen));
endmodule

// File: rtl/dpl_lock_filt.sv
// Module: lock filter with hysteresis for one channel.
// Big errors drop lock immediately. Lock is granted after LOCK_RUN
// consecutive small errors, and mid-band errors restart the run.
// Assumes LOCK_MAX < UNLOCK_MIN and LOCK_RUN >= 1.
module dpl_lock_filt #(
    parameter int LOCK_MAX   = 6,
    parameter int UNLOCK_MIN = 10,
    parameter int LOCK_RUN   = 3,
    parameter int ERR_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             vld_i,
    input  logic [ERR_W-1:0] w_i,
    output logic             locked_o
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [ERR_W-1:0] LMAX = ERR_W'(LOCK_MAX);
    localparam logic [ERR_W-1:0] UMIN = ERR_W'(UNLOCK_MIN);

    logic [RUN_W-1:0] run;

    // Track the run of small errors and update the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            locked_o <= 1'b0;
            run      <= '0;
        end else if (vld_i) begin
            if (w_i >= UMIN) begin
                locked_o <= 1'b0;
                run      <= '0;
            end else if (w_i <= LMAX) begin
                if (run == RUN_LAST) locked_o <= 1'b1;
                else                 run      <= run + 1'b1;
            end else begin
                run <= '0;
            end
        end
    end

    // R6: a big error clears lock on the next cycle.
    a_r6_big_error_unlocks: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        (vld_i && w_i >= UMIN) |=> !locked_o);

    // R5: lock only rises right after a small-error measurement.
    a_r5_rise_after_small: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        $rose(locked_o) |-> $past(vld_i && w_i <= LMAX));

    // R7: a mid-band error leaves the lock flag as it was.
    a_r7_mid_band_keeps: assert property (@(posedge clk) disable iff (!rst_n || hold_i)
        (vld_i && w_i > LMAX && w_i < UMIN) |=> (locked_o == $past(locked_o)));
endmodule

// File: rtl/dual_pfd_lock.sv
// Module: two-channel phase comparator with combined lock and monitor.
// Instantiates a comparator and a lock filter per channel. It forms the
// tri-state drive from the switch pair, ANDs channel lock states (sleep
// counts as locked) and muxes the monitor output.
// Assumes all pulse inputs are synchronous to clk.
module dual_pfd_lock #(
    parameter int DZ_CYC     = 2,
    parameter int LOCK_MAX   = 6,
    parameter int UNLOCK_MIN = 10,
    parameter int LOCK_RUN   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fr_i,
    input  logic [1:0] fp_i,
    input  logic [1:0] sleep_i,
    input  logic [1:0] pol_i,
    input  logic       mon_lds_i,
    input  logic [1:0] mon_src_i,
    output logic [1:0] pump_up_o,
    output logic [1:0] pump_dn_o,
    output logic [1:0] drv_en_o,
    output logic [1:0] drv_lvl_o,
    output logic       lock_o,
    output logic       mon_o
);
    import dpl_pkg::*;

    localparam int NUM_CH = 2;
    localparam int ERR_W  = $clog2(UNLOCK_MIN + 1) + 1;

    logic [NUM_CH-1:0] ch_locked, ch_ok;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             vld;
        logic [ERR_W-1:0] width;

        dpl_pfd #(.DZ_CYC(DZ_CYC), .ERR_W(ERR_W)) u_pfd (
            .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i[c]),
            .fr_i(fr_i[c]), .fp_i(fp_i[c]),
            .up_o(pump_up_o[c]), .dn_o(pump_dn_o[c]),
            .meas_vld_o(vld), .meas_w_o(width)
        );

        dpl_lock_filt #(.LOCK_MAX(LOCK_MAX), .UNLOCK_MIN(UNLOCK_MIN),
                        .LOCK_RUN(LOCK_RUN), .ERR_W(ERR_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .hold_i(sleep_i[c]),
            .vld_i(vld), .w_i(width), .locked_o(ch_locked[c])
        );

        // Tri-state drive: enabled when exactly one switch is closed.
        always_comb begin
            drv_en_o[c]  = pump_up_o[c] ^ pump_dn_o[c];
            drv_lvl_o[c] = drv_en_o[c] & (pol_i[c] ? pump_up_o[c] : pump_dn_o[c]);
            ch_ok[c]     = ch_locked[c] | sleep_i[c];
        end
    end

    // Combined lock and monitor selection.
    always_comb begin
        lock_o = &ch_ok;
        if (!mon_lds_i) begin
            mon_o = lock_o;
        end else begin
            case (mon_src_e'(mon_src_i))
                MON_REF_A: mon_o = fr_i[0];
                MON_REF_B: mon_o = fr_i[1];
                MON_DIV_A: mon_o = fp_i[0];
                default:   mon_o = fp_i[1];
            endcase
        end
    end
endmodule

// File: tb/tb_dual_pfd_lock.sv
module tb_dual_pfd_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fr = '0, fp = '0, sleep = '0, pol = 2'b11;
    logic       lds = 1'b0;
    logic [1:0] src = '0;
    logic [1:0] up, dn, en, lvl;
    logic       lock, mon;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    dual_pfd_lock dut (
        .clk(clk), .rst_n(rst_n), .fr_i(fr), .fp_i(fp), .sleep_i(sleep),
        .pol_i(pol), .mon_lds_i(lds), .mon_src_i(src),
        .pump_up_o(up), .pump_dn_o(dn), .drv_en_o(en), .drv_lvl_o(lvl),
        .lock_o(lock), .mon_o(mon)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One comparison on channel ch; k = 0 means same-cycle arrival.
    task automatic compare(input int ch, input bit fr_first, input int k, input string req);
        int exp_lvl;
        exp_lvl = fr_first ? pol[ch] : ~pol[ch] & 1;
        @(negedge clk);
        if (k == 0) begin fr[ch] = 1'b1; fp[ch] = 1'b1; end
        else if (fr_first) fr[ch] = 1'b1;
        else fp[ch] = 1'b1;
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            fr[ch] = 1'b0; fp[ch] = 1'b0;
            chk({req, " drive enable"}, en[ch], 1);
            chk({req, " drive level"}, lvl[ch], exp_lvl);
            if (i == k) begin
                if (fr_first) fp[ch] = 1'b1; else fr[ch] = 1'b1;
            end
        end
        @(negedge clk);
        fr[ch] = 1'b0; fp[ch] = 1'b0;
        chk("R4 both switches first", {up[ch], dn[ch], en[ch]}, 3'b110);
        @(negedge clk);
        chk("R4 both switches second", {up[ch], dn[ch], en[ch]}, 3'b110);
        @(negedge clk);
        chk("R4 switches open after tail", {up[ch], dn[ch]}, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 pumps idle", {up, dn, en}, 0);
        chk("R1 lock low", lock, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lock low after release", lock, 0);
    endtask

    task automatic t_lead_and_lock;
        sleep[1] = 1'b1;
        compare(0, 1'b1, 3, "R2 reference leads");
        chk("R5 one good not locked", lock, 0);
        compare(0, 1'b0, 2, "R3 divider leads");
        chk("R5 two good not locked", lock, 0);
        compare(0, 1'b1, 0, "R4 same cycle");
        chk("R5 locked after three", lock, 1);
    endtask

    task automatic t_unlock;
        compare(0, 1'b1, 9, "R6 width 9");
        chk("R6 width 9 keeps lock", lock, 1);
        compare(0, 1'b1, 10, "R6 width 10");
        chk("R6 width 10 drops lock", lock, 0);
    endtask

    task automatic t_mid_band;
        compare(0, 1'b1, 2, "R7 run a");
        compare(0, 1'b1, 2, "R7 run b");
        compare(0, 1'b1, 8, "R7 mid");
        chk("R7 mid band keeps unlocked", lock, 0);
        compare(0, 1'b0, 2, "R7 run c");
        compare(0, 1'b1, 2, "R7 run d");
        chk("R7 run restarted", lock, 0);
        compare(0, 1'b1, 6, "R5 boundary 6");
        chk("R5 width 6 completes run", lock, 1);
    endtask

    task automatic t_polarity;
        pol[0] = 1'b0;
        compare(0, 1'b1, 2, "R2 inverted polarity");
        compare(0, 1'b0, 2, "R3 inverted polarity");
        pol[0] = 1'b1;
    endtask

    task automatic t_combined;
        sleep[1] = 1'b0;
        @(negedge clk);
        chk("R9 awake unlocked channel", lock, 0);
        for (int i = 0; i < 3; i++) compare(1, 1'b1, 1, "R9 channel 1");
        chk("R9 both locked", lock, 1);
    endtask

    task automatic t_sleep;
        compare(0, 1'b1, 12, "R6 unlock ch0");
        chk("R9 ch0 unlocked drops combined", lock, 0);
        @(negedge clk);
        fr[0] = 1'b1;
        @(negedge clk);
        fr[0] = 1'b0;
        sleep[0] = 1'b1;
        #1;
        chk("R8 switches open at once", {up[0], dn[0], en[0]}, 0);
        @(negedge clk);
        fr[0] = 1'b1;
        @(negedge clk);
        fr[0] = 1'b0;
        chk("R8 pulse ignored asleep", {up[0], dn[0], en[0]}, 0);
        chk("R8 sleeping counts locked", lock, 1);
        @(negedge clk);
        sleep[0] = 1'b0;
        #1;
        chk("R8 wakes unlocked", lock, 0);
    endtask

    task automatic t_repeat;
        compare(0, 1'b1, 2, "R11 pre a");
        compare(0, 1'b1, 2, "R11 pre b");
        @(negedge clk);
        fr[0] = 1'b1;
        repeat (4) @(negedge clk) fr[0] = 1'b0;
        fr[0] = 1'b1;
        @(negedge clk);
        fr[0] = 1'b0;
        chk("R11 still driving", en[0], 1);
        repeat (3) @(negedge clk);
        fp[0] = 1'b1;
        @(negedge clk);
        fp[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 width from first pulse", lock, 0);
    endtask

    task automatic t_monitor;
        sleep = 2'b11;
        @(negedge clk);
        lds = 1'b0;
        #1;
        chk("R10 monitor shows lock", mon, lock);
        lds = 1'b1;
        fr = 2'b10; fp = 2'b01;
        for (int s = 0; s < 4; s++) begin
            src = 2'(s);
            #1;
            chk("R10 monitor source", mon, (s == 1 || s == 2) ? 1 : 0);
        end
        fr = 2'b01; fp = 2'b10;
        for (int s = 0; s < 4; s++) begin
            src = 2'(s);
            #1;
            chk("R10 monitor source swapped", mon, (s == 0 || s == 3) ? 1 : 0);
        end
        fr = '0; fp = '0; lds = 1'b0;
    endtask

    initial begin
        t_reset;
        t_lead_and_lock;
        t_unlock;
        t_mid_band;
        t_polarity;
        t_combined;
        t_sleep;
        t_repeat;
        t_monitor;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule